// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Programming Port

This block holds the two threshold offsets that a FIFO flag generator compares against its fill level: the almost-empty offset and the almost-full offset. A host programs them and reads them back over the FIFO's own data buses, so no separate configuration interface is needed. An offset-select input is combined with the write enable on the write clock to turn that write-clock cycle into an offset write. On the read clock, the same input combined with the read enable turns that cycle into an offset readback.

Neither access carries an address. A write-side sequence pointer and an independent read-side sequence pointer each step through the two registers in a fixed order: almost-empty first, then almost-full, then back to almost-empty. Each offset is `$clog2(DEPTH)` bits wide and sits in the low bits of the data word. Reset drops any programmed values, restores a default that depends on the depth, and returns both pointers to the almost-empty register. The flag logic treats both offsets as quasi-static. The queue storage itself lies outside this block.

Top module: `ofs_prog_port`

## Requirements
- R1: While `rst_n` is low, both offsets take the default value and `rb_data` is 0. The default is 31 for DEPTH 256, 63 for DEPTH 512 and 127 for larger depths, so it is 127 at the default DEPTH of 1024.
- R2: A rising `wr_clk` edge with `wr_en`=1 and `ofs_sel`=1 is an offset write. Successive offset writes load `ae_ofs`, then `af_ofs`, then `ae_ofs` again, and so on. The register that is not selected keeps its value.
- R3: A rising `wr_clk` edge with `wr_en`=1 and `ofs_sel`=0 is a queue write. It changes neither offset and does not advance the write sequence.
- R4: A rising `rd_clk` edge with `rd_en`=1 and `ofs_sel`=1 is an offset readback. It registers the selected offset onto `rb_data`, and successive readbacks return `ae_ofs`, then `af_ofs`, alternating.
- R5: Only `din[OFS_W-1:0]` is stored by an offset write, and the bits above it are ignored. On readback, `rb_data` bits above OFS_W are driven 0.
- R6: The read sequence advances only on offset readbacks, independently of how many offset writes have occurred.
- R7: A rising `rd_clk` edge with `ofs_sel`=0, or with `rd_en`=0, leaves `rb_data` and the read sequence unchanged.
- R8: Reset returns both sequence pointers to the almost-empty register, even when it arrives in the middle of a write pair or a read pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ofs_sel | input | 1 | 1 selects offset access instead of a queue access |
| wr_en | input | 1 | Write enable (active high) |
| rd_en | input | 1 | Read enable (active high) |
| din | input | DATA_W | Write data bus |
| ae_ofs | output | OFS_W | Almost-empty offset to the flag logic |
| af_ofs | output | OFS_W | Almost-full offset to the flag logic |
| rb_data | output | DATA_W | Offset readback word |

## Verification
The bench drives a write pair whose upper data bits are all ones. This shows that the values are steered to the correct register and that the ignored bits are dropped. A second pair then confirms that the sequence wraps around. A queue write placed between offset writes, and queue reads placed between readbacks, tell a sequencer that counts every enable apart from one that counts only offset accesses. An odd number of readbacks leaves the read pointer out of step with the write pointer, which exposes any coupling between the two pointers. Reset is asserted while both pointers sit on the almost-full register. The following write and read must land on the almost-empty register, and the offsets must return to their defaults.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;

  // Which of the two offset registers an access reaches.
  typedef enum logic {
    SLOT_AE = 1'b0,
    SLOT_AF = 1'b1
  } slot_e;

  // Default offset by queue depth.
  function automatic int unsigned default_offset(int unsigned depth);
    if (depth <= 256)      return 31;
    else if (depth <= 512) return 63;
    else                   return 127;
  endfunction

  // Sequence step: the two slots alternate.
  function automatic slot_e next_slot(slot_e cur);
    return (cur == SLOT_AE) ? SLOT_AF : SLOT_AE;
  endfunction

endpackage

// File: rtl/ofs_wr_seq.sv
module ofs_wr_seq
  import ofs_prog_pkg::*;
#(
  parameter int unsigned OFS_W = 10,
  parameter logic [OFS_W-1:0] DFLT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             ofs_sel,
  input  logic [OFS_W-1:0] wdata,
  output logic [OFS_W-1:0] ae_q,
  output logic [OFS_W-1:0] af_q,
  output slot_e            ptr_q,
  output logic             evt
);

  assign evt = wr_en & ofs_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_q  <= DFLT;
      af_q  <= DFLT;
      ptr_q <= SLOT_AE;
    end else if (evt) begin
      if (ptr_q == SLOT_AE) ae_q <= wdata;
      else                  af_q <= wdata;
      ptr_q <= next_slot(ptr_q);
    end
  end

endmodule

// File: rtl/ofs_rd_seq.sv
module ofs_rd_seq
  import ofs_prog_pkg::*;
#(
  parameter int unsigned OFS_W  = 10,
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              ofs_sel,
  input  logic [OFS_W-1:0]  ae_i,
  input  logic [OFS_W-1:0]  af_i,
  output logic [DATA_W-1:0] rb_q,
  output slot_e             ptr_q,
  output logic              evt
);

  localparam int unsigned PAD_W = DATA_W - OFS_W;

  logic [OFS_W-1:0]  pick;
  logic [DATA_W-1:0] rb_next;

  assign evt  = rd_en & ofs_sel;
  assign pick = (ptr_q == SLOT_AE) ? ae_i : af_i;

  generate
    if (PAD_W > 0) begin : g_pad
      assign rb_next = {{PAD_W{1'b0}}, pick};
    end else begin : g_nopad
      assign rb_next = pick[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q  <= '0;
      ptr_q <= SLOT_AE;
    end else if (evt) begin
      rb_q  <= rb_next;
      ptr_q <= next_slot(ptr_q);
    end
  end

endmodule

// File: rtl/ofs_prog_port.sv
module ofs_prog_port
  import ofs_prog_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned DATA_W = 18
) (
  input  logic                       wr_clk,
  input  logic                       rd_clk,
  input  logic                       rst_n,
  input  logic                       ofs_sel,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [DATA_W-1:0]          din,
  output logic [$clog2(DEPTH)-1:0]   ae_ofs,
  output logic [$clog2(DEPTH)-1:0]   af_ofs,
  output logic [DATA_W-1:0]          rb_data
);

  localparam int unsigned OFS_W = $clog2(DEPTH);
  localparam logic [OFS_W-1:0] DFLT = OFS_W'(default_offset(DEPTH));

  // Internal events brought out for the checker.
  slot_e wr_ptr;
  slot_e rd_ptr;
  logic  ofs_wr_evt;
  logic  ofs_rd_evt;

  ofs_wr_seq #(
    .OFS_W (OFS_W),
    .DFLT  (DFLT)
  ) u_wr (
    .clk     (wr_clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .ofs_sel (ofs_sel),
    .wdata   (din[OFS_W-1:0]),
    .ae_q    (ae_ofs),
    .af_q    (af_ofs),
    .ptr_q   (wr_ptr),
    .evt     (ofs_wr_evt)
  );

  ofs_rd_seq #(
    .OFS_W  (OFS_W),
    .DATA_W (DATA_W)
  ) u_rd (
    .clk     (rd_clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .ofs_sel (ofs_sel),
    .ae_i    (ae_ofs),
    .af_i    (af_ofs),
    .rb_q    (rb_data),
    .ptr_q   (rd_ptr),
    .evt     (ofs_rd_evt)
  );

endmodule

// File: rtl/ofs_prog_chk.sv
module ofs_prog_chk
  import ofs_prog_pkg::*;
#(
  parameter int unsigned OFS_W  = 10,
  parameter int unsigned DATA_W = 18
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              ofs_sel,
  input logic [OFS_W-1:0]  ae_ofs,
  input logic [OFS_W-1:0]  af_ofs,
  input logic [DATA_W-1:0] rb_data,
  input slot_e             wr_ptr,
  input slot_e             rd_ptr,
  input logic              ofs_wr_evt,
  input logic              ofs_rd_evt
);

  // R2
  wr_alternate_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    ofs_wr_evt |=> wr_ptr != $past(wr_ptr));

  // R2
  ae_write_spares_af_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (ofs_wr_evt && wr_ptr == SLOT_AE) |=> $stable(af_ofs));

  // R2
  af_write_spares_ae_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (ofs_wr_evt && wr_ptr == SLOT_AF) |=> $stable(ae_ofs));

  // R3
  queue_write_keeps_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && !ofs_sel) |=> ($stable(ae_ofs) && $stable(af_ofs) && $stable(wr_ptr)));

  // R4
  rd_alternate_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    ofs_rd_evt |=> rd_ptr != $past(rd_ptr));

  // R5
  rb_upper_zero_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    ofs_rd_evt |=> rb_data[DATA_W-1:OFS_W] == '0);

  // R7
  rb_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !ofs_rd_evt |=> ($stable(rb_data) && $stable(rd_ptr)));

endmodule

bind ofs_prog_port ofs_prog_chk #(
  .OFS_W  (OFS_W),
  .DATA_W (DATA_W)
) u_chk (
  .wr_clk     (wr_clk),
  .rd_clk     (rd_clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .ofs_sel    (ofs_sel),
  .ae_ofs     (ae_ofs),
  .af_ofs     (af_ofs),
  .rb_data    (rb_data),
  .wr_ptr     (wr_ptr),
  .rd_ptr     (rd_ptr),
  .ofs_wr_evt (ofs_wr_evt),
  .ofs_rd_evt (ofs_rd_evt)
);

// File: tb/ofs_prog_port_bench.sv
`timescale 1ns/1ps
module ofs_prog_port_bench;

  localparam int DEPTH  = 1024;
  localparam int DATA_W = 18;
  localparam int OFS_W  = 10;
  localparam logic [OFS_W-1:0] DFLT = 10'd127;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic rst_n  = 1'b0;
  logic ofs_sel = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [OFS_W-1:0]  ae_ofs, af_ofs;
  logic [DATA_W-1:0] rb_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 wr_clk = ~wr_clk;
  initial begin
    #3;
    forever #5 rd_clk = ~rd_clk;
  end

  ofs_prog_port #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ofs_prog_port (
    .wr_clk (wr_clk), .rd_clk (rd_clk), .rst_n (rst_n),
    .ofs_sel (ofs_sel), .wr_en (wr_en), .rd_en (rd_en), .din (din),
    .ae_ofs (ae_ofs), .af_ofs (af_ofs), .rb_data (rb_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One write-clock cycle with the given controls.
  task automatic wr_cycle(logic sel, logic [DATA_W-1:0] d);
    @(negedge wr_clk);
    ofs_sel = sel; wr_en = 1'b1; din = d;
    @(negedge wr_clk);
    wr_en = 1'b0; ofs_sel = 1'b0; din = '0;
  endtask

  // One read-clock cycle with the given controls.
  task automatic rd_cycle(logic sel, logic en);
    @(negedge rd_clk);
    ofs_sel = sel; rd_en = en;
    @(negedge rd_clk);
    rd_en = 1'b0; ofs_sel = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge wr_clk);
    rst_n = 1'b0;
    #1;
    // R1: defaults while reset is held
    check("R1 ae default", 32'(ae_ofs), 32'(DFLT));
    check("R1 af default", 32'(af_ofs), 32'(DFLT));
    check("R1 readback zero", 32'(rb_data), 32'h0);
    repeat (3) @(negedge wr_clk);
    rst_n = 1'b1;
  endtask

  task automatic t_write_pair();
    wr_cycle(1'b1, {8'hFF, 10'h155});
    check("R2 first write to ae", 32'(ae_ofs), 32'h155);
    check("R2 af untouched", 32'(af_ofs), 32'(DFLT));
    wr_cycle(1'b1, {8'hFF, 10'h2AA});
    check("R2 second write to af", 32'(af_ofs), 32'h2AA);
    check("R5 upper bits ignored", 32'(ae_ofs), 32'h155);
    wr_cycle(1'b1, 18'h000F0);
    check("R2 wrap to ae", 32'(ae_ofs), 32'h0F0);
    wr_cycle(1'b1, 18'h0030F);
    check("R2 wrap to af", 32'(af_ofs), 32'h30F);
  endtask

  task automatic t_queue_write();
    wr_cycle(1'b0, 18'h3FFFF);
    check("R3 queue write keeps ae", 32'(ae_ofs), 32'h0F0);
    check("R3 queue write keeps af", 32'(af_ofs), 32'h30F);
    wr_cycle(1'b1, 18'h00011);
    check("R3 sequence not advanced", 32'(ae_ofs), 32'h011);
    wr_cycle(1'b1, 18'h00022);
    check("R2 af after queue write", 32'(af_ofs), 32'h022);
  endtask

  task automatic t_readback();
    rd_cycle(1'b1, 1'b1);
    check("R4 first readback ae, R5 upper zero", 32'(rb_data), 32'h011);
    rd_cycle(1'b0, 1'b1);
    check("R7 queue read holds readback", 32'(rb_data), 32'h011);
    rd_cycle(1'b1, 1'b0);
    check("R7 no enable holds readback", 32'(rb_data), 32'h011);
    rd_cycle(1'b1, 1'b1);
    check("R4 second readback af", 32'(rb_data), 32'h022);
    rd_cycle(1'b1, 1'b1);
    check("R4 third readback ae", 32'(rb_data), 32'h011);
  endtask

  task automatic t_independent();
    // Write pointer is on ae; read pointer is on af.
    rd_cycle(1'b1, 1'b1);
    check("R6 read seq independent of write seq", 32'(rb_data), 32'h022);
  endtask

  task automatic t_reset_midway();
    wr_cycle(1'b1, 18'h00044);
    check("R2 ae before reset", 32'(ae_ofs), 32'h044);
    rd_cycle(1'b1, 1'b1);
    check("R4 readback before reset", 32'(rb_data), 32'h044);
    do_reset();
    wr_cycle(1'b1, 18'h00055);
    check("R8 write pointer back on ae", 32'(ae_ofs), 32'h055);
    check("R8 af still default", 32'(af_ofs), 32'(DFLT));
    rd_cycle(1'b1, 1'b1);
    check("R8 read pointer back on ae", 32'(rb_data), 32'h055);
  endtask

  initial begin
    do_reset();
    t_write_pair();
    t_queue_write();
    t_readback();
    t_independent();
    t_reset_midway();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge wr_clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule